// File: doc/BRIEF.md
# Programmable LED Blink Generator

This block drives a status-LED waveform onto one GPIO pin picked by software. It sits beside the GPIO logic of two ports, port A (8 pins) and port B (7 pins). For every pin it produces an override-enable bit and an override value. The GPIO pad multiplexer uses these bits to replace whatever that pin would otherwise do. The override wins whether the pin is set up as an input or as an output.

One 8-bit configuration byte controls the block. It enables the function, picks a blink rate or a static level, picks the port, and picks the pin inside that port. A single free-running prescaler, sized from the system clock frequency, divides the clock into a phase counter. The three blink rates (1 Hz, 1/2 Hz and 1/4 Hz, all 50% duty) are bits of that one counter, so they stay phase-aligned. While the function is enabled, a new rate code is held back until the next half-period boundary of the 1 Hz wave, so a rate change never cuts a pulse short.

Top module: `pled_blink_gen`

## Requirements
- R1: After reset the configuration byte is 0x00, and every bit of `ovr_en_a`, `ovr_val_a`, `ovr_en_b` and `ovr_val_b` is 0.
- R2: Configuration bit 7 enables the function. While it is 0, no override-enable bit is set. While it is 1 and the pin choice is valid, exactly the chosen pin's override-enable bit is 1, whatever that pin's GPIO direction.
- R3: Bit 3 picks the port (0 = port A, 1 = port B), and bits 2..0 give the pin index within it. Valid indices are 0 to 6 on port A and 3 to 5 on port B. Any other index gives no override on either port.
- R4: Bits 6..4 are the rate code. Code 111 sets the override value to 1 (released/high). Codes 000, 001, 010 and 011 set it to 0 (driven low).
- R5: Let n be the number of clock edges since reset and H = CLK_HZ/2. The wave values are then bit 0 (code 110, 1 Hz), bit 1 (code 101, 1/2 Hz) and bit 2 (code 100, 1/4 Hz) of floor(n/H) mod 8. Each wave is 50% duty and starts low after reset.
- R6: A rate code written while the function is enabled takes effect only on an edge where n is a multiple of H. A rate written while the function is disabled takes effect with the write.
- R7: The override value of every pin whose override-enable bit is 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ cycles per second |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Loads `cfg_wdata` into the configuration byte on this edge |
| cfg_wdata | input | 8 | New configuration: [7] enable, [6:4] rate code, [3] port, [2:0] pin |
| ovr_en_a | output | A_W | Port A per-pin override enable |
| ovr_val_a | output | A_W | Port A per-pin override value |
| ovr_en_b | output | B_W | Port B per-pin override enable |
| ovr_val_b | output | B_W | Port B per-pin override value |

## Verification
The rate field is tried with every static code, including the three undefined low codes, to tell the released level from the driven-low level. Each of the three blink codes is then held for several full periods, so that a wrong divider bit or a lost phase alignment shows up as a mismatch against the edge count. The pin field is swept across both ports, at valid indices and at indices just outside each valid range, to catch a wrong decode window or a leak to the other port. Rate writes placed mid-period, and writes made while disabled, separate the deferred update from the immediate one.

// File: rtl/pled_pkg.sv
package pled_pkg;

    // Rate codes with a defined meaning; every other code drives low
    localparam logic [2:0] RATE_STATIC_HI = 3'b111;
    localparam logic [2:0] RATE_ONE_HZ    = 3'b110;
    localparam logic [2:0] RATE_HALF_HZ   = 3'b101;
    localparam logic [2:0] RATE_QTR_HZ    = 3'b100;

    // Field order of the configuration byte, MSB first
    typedef struct packed {
        logic       enable;
        logic [2:0] rate;
        logic       port_b;
        logic [2:0] pin;
    } led_cfg_t;

    function automatic logic pick_wave(input logic [2:0] rate, input logic [2:0] phase);
        logic w;
        case (rate)
            RATE_STATIC_HI: w = 1'b1;
            RATE_ONE_HZ:    w = phase[0];
            RATE_HALF_HZ:   w = phase[1];
            RATE_QTR_HZ:    w = phase[2];
            default:        w = 1'b0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/pled_prescaler.sv
module pled_prescaler #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       half_tick,
    output logic [2:0] phase
);
    localparam int HALF_CYC = (CLK_HZ / 2 > 1) ? CLK_HZ / 2 : 1;
    localparam int CW       = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [2:0]    phase;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        half_tick = (st_q.cnt == CNT_LAST);
        if (half_tick) begin
            st_d.cnt   = '0;
            st_d.phase = st_q.phase + 3'd1;
        end else begin
            st_d.cnt   = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase = st_q.phase;

    // R5: the phase advances by one exactly on a boundary
    a_r5_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        half_tick |=> (phase == $past(phase) + 3'd1));

    a_r5_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !half_tick |=> $stable(phase));

endmodule

// File: rtl/pled_rate_sel.sv
module pled_rate_sel
    import pled_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       led_on,
    input  logic       cfg_wr,
    input  logic [2:0] wr_rate,
    input  logic [2:0] cur_rate,
    input  logic       half_tick,
    input  logic [2:0] phase,
    output logic       wave
);
    typedef struct packed {
        logic [2:0] act;
    } rate_st_t;

    rate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!led_on || half_tick) begin
            st_d.act = cfg_wr ? wr_rate : cur_rate;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wave = pick_wave(st_q.act, phase);

    // R6: while enabled the active rate only moves on a boundary
    a_r6_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        (led_on && !half_tick) |=> $stable(st_q.act));

    // R6: while disabled the active rate tracks the stored code
    a_r6_follow_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!led_on && !cfg_wr) |=> (st_q.act == $past(cur_rate)));

    // R4: low codes never produce a high value
    a_r4_low_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act[2] == 1'b0) |-> !wave);

endmodule

// File: rtl/pled_pin_route.sv
module pled_pin_route
    import pled_pkg::*;
#(
    parameter int A_W  = 8,
    parameter int B_W  = 7,
    parameter int A_LO = 0,
    parameter int A_HI = 6,
    parameter int B_LO = 3,
    parameter int B_HI = 5
) (
    input  led_cfg_t       cfg,
    input  logic           wave,
    output logic [A_W-1:0] en_a,
    output logic [A_W-1:0] val_a,
    output logic [B_W-1:0] en_b,
    output logic [B_W-1:0] val_b
);
    for (genvar i = 0; i < A_W; i++) begin : g_a
        if (i >= A_LO && i <= A_HI) begin : g_ok
            assign en_a[i] = cfg.enable && !cfg.port_b && (cfg.pin == 3'(i));
        end else begin : g_no
            assign en_a[i] = 1'b0;
        end
        assign val_a[i] = en_a[i] & wave;
    end

    for (genvar j = 0; j < B_W; j++) begin : g_b
        if (j >= B_LO && j <= B_HI) begin : g_ok
            assign en_b[j] = cfg.enable && cfg.port_b && (cfg.pin == 3'(j));
        end else begin : g_no
            assign en_b[j] = 1'b0;
        end
        assign val_b[j] = en_b[j] & wave;
    end

endmodule

// File: rtl/pled_blink_gen.sv
module pled_blink_gen
    import pled_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int A_W    = 8,
    parameter int B_W    = 7,
    parameter int A_LO   = 0,
    parameter int A_HI   = 6,
    parameter int B_LO   = 3,
    parameter int B_HI   = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wr,
    input  logic [7:0]     cfg_wdata,
    output logic [A_W-1:0] ovr_en_a,
    output logic [A_W-1:0] ovr_val_a,
    output logic [B_W-1:0] ovr_en_b,
    output logic [B_W-1:0] ovr_val_b
);
    led_cfg_t   cfg_d, cfg_q;
    led_cfg_t   wr_cfg;
    logic       half_tick;
    logic [2:0] phase;
    logic       wave;

    assign wr_cfg = led_cfg_t'(cfg_wdata);

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) cfg_d = wr_cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    pled_prescaler #(.CLK_HZ(CLK_HZ)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_tick (half_tick),
        .phase     (phase)
    );

    pled_rate_sel u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .led_on    (cfg_q.enable),
        .cfg_wr    (cfg_wr),
        .wr_rate   (wr_cfg.rate),
        .cur_rate  (cfg_q.rate),
        .half_tick (half_tick),
        .phase     (phase),
        .wave      (wave)
    );

    pled_pin_route #(
        .A_W (A_W), .B_W (B_W),
        .A_LO(A_LO), .A_HI(A_HI), .B_LO(B_LO), .B_HI(B_HI)
    ) u_route (
        .cfg   (cfg_q),
        .wave  (wave),
        .en_a  (ovr_en_a),
        .val_a (ovr_val_a),
        .en_b  (ovr_en_b),
        .val_b (ovr_val_b)
    );

    // R3: at most one pin is overridden across both ports
    a_r3_single_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovr_en_a, ovr_en_b}));

    // R2: no override while the function is off
    a_r2_off_no_override: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.enable |-> (ovr_en_a == '0 && ovr_en_b == '0));

    // R3: a port B index outside its window overrides nothing
    a_r3_b_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.port_b && (int'(cfg_q.pin) < B_LO || int'(cfg_q.pin) > B_HI))
            |-> (ovr_en_a == '0 && ovr_en_b == '0));

    // R7: values are masked by the enables
    a_r7_value_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovr_val_a & ~ovr_en_a) == '0) && ((ovr_val_b & ~ovr_en_b) == '0));

endmodule

// File: tb/sim_pled_blink_gen.sv
`timescale 1ns/1ps
module sim_pled_blink_gen;
    localparam int CLK_HZ = 16;
    localparam int HALF   = CLK_HZ / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] ovr_en_a, ovr_val_a;
    logic [6:0] ovr_en_b, ovr_val_b;

    always #10 clk = ~clk;

    pled_blink_gen #(.CLK_HZ(CLK_HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .ovr_en_a(ovr_en_a), .ovr_val_a(ovr_val_a),
        .ovr_en_b(ovr_en_b), .ovr_val_b(ovr_val_b)
    );

    typedef struct {
        logic [7:0] ea, va;
        logic [6:0] eb, vb;
        string      tag;
    } exp_t;

    exp_t  sb_q[$];
    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Reference model, built from the requirements
    logic [7:0] m_cfg = 8'h00;
    logic [2:0] m_act = 3'b000;
    int         m_n = 0;

    function automatic logic wave_of(input logic [2:0] r, input logic [2:0] ph);
        case (r)
            3'b111: return 1'b1;
            3'b110: return ph[0];
            3'b101: return ph[1];
            3'b100: return ph[2];
            default: return 1'b0;
        endcase
    endfunction

    // Driver side of the scoreboard: one expected item per edge
    always @(posedge clk) begin
        exp_t e;
        logic [2:0] ph;
        logic w;
        int   pin;
        if (!rst_n) begin
            m_cfg = 8'h00; m_act = 3'b000; m_n = 0;
        end else begin
            int  n_new;
            bit  tick;
            n_new = m_n + 1;
            tick  = (n_new % HALF) == 0;
            if (cfg_wr) begin
                if (!m_cfg[7] || tick) m_act = cfg_wdata[6:4];
                m_cfg = cfg_wdata;
            end else if (!m_cfg[7] || tick) begin
                m_act = m_cfg[6:4];
            end
            m_n = n_new;
        end
        ph  = 3'((m_n / HALF) % 8);
        w   = wave_of(m_act, ph);
        pin = int'(m_cfg[2:0]);
        e.ea = '0; e.va = '0; e.eb = '0; e.vb = '0; e.tag = cur_req;
        if (m_cfg[7]) begin
            if (!m_cfg[3] && pin <= 6) begin e.ea[pin] = 1'b1; e.va[pin] = w; end
            if (m_cfg[3] && pin >= 3 && pin <= 5) begin e.eb[pin] = 1'b1; e.vb[pin] = w; end
        end
        sb_q.push_back(e);
    end

    // Monitor side: compare mid-cycle
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (ovr_en_a !== e.ea || ovr_val_a !== e.va || ovr_en_b !== e.eb || ovr_val_b !== e.vb) begin
                failures++;
                $display("FAIL %s t=%0t en_a=%h val_a=%h en_b=%h val_b=%h expected en_a=%h val_a=%h en_b=%h val_b=%h",
                         e.tag, $time, ovr_en_a, ovr_val_a, ovr_en_b, ovr_val_b, e.ea, e.va, e.eb, e.vb);
            end
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic write_cfg(input logic [7:0] d);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state, checked directly and by the scoreboard
        cur_req = "R1";
        wait_cyc(3);
        rst_n = 1'b1;
        checks++;
        if (ovr_en_a !== 8'h00 || ovr_val_a !== 8'h00 || ovr_en_b !== 7'h00 || ovr_val_b !== 7'h00) begin
            failures++;
            $display("FAIL R1 outputs after reset en_a=%h val_a=%h en_b=%h val_b=%h expected all 0",
                     ovr_en_a, ovr_val_a, ovr_en_b, ovr_val_b);
        end
        wait_cyc(5);

        // R4: static codes on port A pin 2
        cur_req = "R4";
        write_cfg(8'h82); wait_cyc(12);
        write_cfg(8'hF2); wait_cyc(12);
        write_cfg(8'h92); wait_cyc(12);
        write_cfg(8'hA2); wait_cyc(12);
        write_cfg(8'hB2); wait_cyc(12);

        // R3: pin window on both ports, inside and just outside
        cur_req = "R3";
        write_cfg(8'hF0); wait_cyc(10);
        write_cfg(8'hF6); wait_cyc(10);
        write_cfg(8'hF7); wait_cyc(10);
        write_cfg(8'hFB); wait_cyc(10);
        write_cfg(8'hFD); wait_cyc(10);
        write_cfg(8'hFA); wait_cyc(10);
        write_cfg(8'hFE); wait_cyc(10);

        // R2: disable then re-enable; direction of the pin plays no part
        cur_req = "R2";
        write_cfg(8'h74); wait_cyc(10);
        write_cfg(8'hF4); wait_cyc(10);
        write_cfg(8'h04); wait_cyc(6);

        // R5: each blink rate over several periods
        cur_req = "R5";
        write_cfg(8'hE1); wait_cyc(6 * HALF);
        write_cfg(8'hD1); wait_cyc(8 * HALF);
        write_cfg(8'hC1); wait_cyc(16 * HALF);
        write_cfg(8'hCC); wait_cyc(16 * HALF);

        // R6: mid-period rate changes while enabled, and writes while disabled
        cur_req = "R6";
        write_cfg(8'hF3); wait_cyc(HALF + 3);
        write_cfg(8'h83); wait_cyc(HALF);
        write_cfg(8'hE3); wait_cyc(3);
        write_cfg(8'hF3); wait_cyc(2 * HALF);
        write_cfg(8'h63); wait_cyc(3);
        write_cfg(8'hE3); wait_cyc(3 * HALF);
        write_cfg(8'h43); wait_cyc(2);
        write_cfg(8'hC5); wait_cyc(9 * HALF);

        // R7: unselected pins stay at value 0 on both ports
        cur_req = "R7";
        write_cfg(8'hFD); wait_cyc(2 * HALF);
        write_cfg(8'hE0); wait_cyc(4 * HALF);

        wait_cyc(2);
        finish_run();
    end

endmodule